// File: doc/BRIEF.md
# Sensor Alert Acknowledge Controller

This block sits between a cluster of analog sensors and a downstream alert handler. It serves a configurable number of alert channels (13 by default). Each channel reaches the block as a pair of request lines: one asserts high, the other asserts low. The two lines are treated as redundant indicators, so a channel counts as active whenever either line sits at its asserted level, whatever the other line is doing. On every cycle a channel is active, the block emits a one-clock event toward the alert handler. It also records the event in a sticky per-channel state bit.

Each channel has a two-bit acknowledge policy, which decides how the sensor learns that its request was seen. In hardware mode the block acknowledges at once. In software mode the acknowledge is held back until software clears the channel's state bit. In the remaining modes the channel is never acknowledged, so the event repeats for as long as the sensor holds its request. A one-way lock bit freezes the policy register. For test use, a write-only pulse register injects a single event and a trigger register forces events continuously. Neither of these ever produces an acknowledge to the sensor.

Software reaches the block through a simple register port: a write strobe, a read strobe, a byte address and a data word. Read data is registered.

Top module: `sensor_alert_ack_ctrl`

## Requirements
- R1: After a synchronous reset, all event and acknowledge outputs are 0, the lock bit (offset 0x04, bit 0) reads 1, and the policy (0x08), trigger (0x0C) and state (0x10) registers read 0.
- R2: A channel is active when its high-asserted line is 1, or its low-asserted line is 0, or both. With the high line at 0 and the low line at 1, the channel is idle.
- R3: For each clock edge at which a channel is active, that channel's event output is 1 for exactly the following cycle. The output returns to 0 after the first idle edge.
- R4: Channel i takes its policy from bits [2i+1:2i] of the register at 0x08, and a read returns the stored value. Code 0 is hardware acknowledge, code 1 is software acknowledge, and codes 2 and 3 mean no acknowledge.
- R5: Under code 0, a sensor request that is active at an edge gives a one-cycle acknowledge pulse on that channel, in the same cycle as its event. Under code 0, writing 1 to the channel's state bit gives no acknowledge.
- R6: Under code 1, a sensor request produces an event but no acknowledge. A write of 1 to the channel's bit at 0x10 while that bit is set produces a one-cycle acknowledge pulse, appearing in the cycle after the write edge, and clears the bit. The same write gives no acknowledge when the bit is already clear.
- R7: Under codes 2 and 3, a held request raises an event every cycle and never produces an acknowledge.
- R8: Each state bit at 0x10 is set by any event on its channel and cleared by writing 1 to it. Writing 0 leaves it unchanged. If a set and a clear happen on the same edge, the set wins.
- R9: Writing 0 to bit 0 at 0x04 clears the lock bit, and writing 1 to it has no effect. While the lock bit is 0, writes to 0x08 are ignored.
- R10: Writing 1 to bit i at 0x00 gives exactly one event on channel i, in the cycle after the write edge, sets state bit i, and gives no acknowledge. Reads of 0x00 return 0.
- R11: While bit i of the trigger register at 0x0C is 1, channel i raises an event every cycle, beginning one cycle after the write that sets the bit. Forced events never acknowledge. The register reads back as written, and writing 0 stops the events after one further cycle.
- R12: A read strobe returns data on the port in the cycle after its edge. Reads of any offset other than 0x00 to 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_hi_i | input | NUM_CH | High-asserted request line of each channel |
| req_lo_n_i | input | NUM_CH | Low-asserted request line of each channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| alert_evt_o | output | NUM_CH | One-cycle event pulses toward the alert handler |
| sensor_ack_o | output | NUM_CH | One-cycle acknowledge pulses toward the sensors |

## Verification
The assertions rely on three properties of the stimulus. The request lines and register strobes change only between clock edges. A register write never targets the policy register in the same cycle it unlocks anything, because the lock can only go from 1 to 0. The word at 0x10 is the only way software clears state. The bench changes all inputs one nanosecond after a rising edge and holds each write strobe for exactly one cycle. It releases sensor requests once the acknowledge or the check has been seen, in the way a real sensor would drop its request.

// File: rtl/sac_pkg.sv
`timescale 1ns/1ps
package sac_pkg;
  // register byte offsets; decode depends on these
  localparam int unsigned OFS_TEST  = 'h00;
  localparam int unsigned OFS_LOCK  = 'h04;
  localparam int unsigned OFS_MODE  = 'h08;
  localparam int unsigned OFS_TRIG  = 'h0C;
  localparam int unsigned OFS_STATE = 'h10;

  typedef enum logic [1:0] {
    ACK_HW    = 2'd0,
    ACK_SW    = 2'd1,
    ACK_NONE  = 2'd2,
    ACK_NONE3 = 2'd3
  } ack_mode_e;
endpackage

// File: rtl/sac_regs.sv
`timescale 1ns/1ps
module sac_regs
  import sac_pkg::*;
#(
  parameter int NUM_CH = 13,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_CH-1:0]     state_i,
  output logic                  lock_en_o,
  output logic [2*NUM_CH-1:0]   mode_o,
  output logic [NUM_CH-1:0]     force_o,
  output logic [NUM_CH-1:0]     test_o,
  output logic [NUM_CH-1:0]     clr_o,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int MODE_W = 2 * NUM_CH;

  logic                lock_en_q;
  logic [MODE_W-1:0]   mode_q;
  logic [NUM_CH-1:0]   trig_q;
  logic [DATA_W-1:0]   rdata_q;
  logic [DATA_W-1:0]   rd_word;
  logic hit_test, hit_lock, hit_mode, hit_trig, hit_state;
  logic unused_wdata;

  assign hit_test  = wr_i && (addr_i == ADDR_W'(OFS_TEST));
  assign hit_lock  = wr_i && (addr_i == ADDR_W'(OFS_LOCK));
  assign hit_mode  = wr_i && (addr_i == ADDR_W'(OFS_MODE));
  assign hit_trig  = wr_i && (addr_i == ADDR_W'(OFS_TRIG));
  assign hit_state = wr_i && (addr_i == ADDR_W'(OFS_STATE));

  assign unused_wdata = ^wdata_i[DATA_W-1:MODE_W];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lock_en_q <= 1'b1;
      mode_q    <= '0;
      trig_q    <= '0;
      rdata_q   <= '0;
    end else begin
      if (hit_lock && !wdata_i[0]) lock_en_q <= 1'b0;
      if (hit_mode && lock_en_q)   mode_q    <= wdata_i[MODE_W-1:0];
      if (hit_trig)                trig_q    <= wdata_i[NUM_CH-1:0];
      if (rd_i)                    rdata_q   <= rd_word;
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr_i == ADDR_W'(OFS_LOCK))       rd_word[0]          = lock_en_q;
    else if (addr_i == ADDR_W'(OFS_MODE))  rd_word[MODE_W-1:0] = mode_q;
    else if (addr_i == ADDR_W'(OFS_TRIG))  rd_word[NUM_CH-1:0] = trig_q;
    else if (addr_i == ADDR_W'(OFS_STATE)) rd_word[NUM_CH-1:0] = state_i;
  end

  assign test_o    = hit_test  ? wdata_i[NUM_CH-1:0] : '0;
  assign clr_o     = hit_state ? wdata_i[NUM_CH-1:0] : '0;
  assign lock_en_o = lock_en_q;
  assign mode_o    = mode_q;
  assign force_o   = trig_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/sac_chan.sv
`timescale 1ns/1ps
module sac_chan
  import sac_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      req_hi_i,
  input  logic      req_lo_n_i,
  input  logic      test_i,
  input  logic      force_i,
  input  ack_mode_e mode_i,
  input  logic      clr_i,
  output logic      evt_o,
  output logic      ack_o,
  output logic      state_o
);
  logic sensor_act, evt_d, ack_d, state_d;
  logic evt_q, ack_q, state_q;

  // either line at its asserted level counts; no complement check
  assign sensor_act = req_hi_i | ~req_lo_n_i;
  assign evt_d      = sensor_act | test_i | force_i;

  always_comb begin
    unique case (mode_i)
      ACK_HW:  ack_d = sensor_act;
      ACK_SW:  ack_d = clr_i & state_q;
      default: ack_d = 1'b0;
    endcase
  end

  // a new event outranks a clearing write on the same edge
  assign state_d = evt_d ? 1'b1 : (clr_i ? 1'b0 : state_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      evt_q   <= 1'b0;
      ack_q   <= 1'b0;
      state_q <= 1'b0;
    end else begin
      evt_q   <= evt_d;
      ack_q   <= ack_d;
      state_q <= state_d;
    end
  end

  assign evt_o   = evt_q;
  assign ack_o   = ack_q;
  assign state_o = state_q;
endmodule

// File: rtl/sensor_alert_ack_ctrl.sv
`timescale 1ns/1ps
module sensor_alert_ack_ctrl
  import sac_pkg::*;
#(
  parameter int NUM_CH = 13,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NUM_CH-1:0] req_hi_i,
  input  logic [NUM_CH-1:0] req_lo_n_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [NUM_CH-1:0] alert_evt_o,
  output logic [NUM_CH-1:0] sensor_ack_o
);
  localparam int MODE_W = 2 * NUM_CH;

  logic                lock_en;
  logic [MODE_W-1:0]   mode_bits;
  logic [NUM_CH-1:0]   force_bits;
  logic [NUM_CH-1:0]   test_bits;
  logic [NUM_CH-1:0]   clr_bits;
  logic [NUM_CH-1:0]   state_bits;

  sac_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .state_i   (state_bits),
    .lock_en_o (lock_en),
    .mode_o    (mode_bits),
    .force_o   (force_bits),
    .test_o    (test_bits),
    .clr_o     (clr_bits),
    .rdata_o   (reg_rdata_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    sac_chan u_chan (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .req_hi_i   (req_hi_i[i]),
      .req_lo_n_i (req_lo_n_i[i]),
      .test_i     (test_bits[i]),
      .force_i    (force_bits[i]),
      .mode_i     (ack_mode_e'(mode_bits[2*i +: 2])),
      .clr_i      (clr_bits[i]),
      .evt_o      (alert_evt_o[i]),
      .ack_o      (sensor_ack_o[i]),
      .state_o    (state_bits[i])
    );
  end
endmodule

// File: rtl/sac_chk.sv
`timescale 1ns/1ps
module sac_chk
  import sac_pkg::*;
#(
  parameter int NUM_CH = 13,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic [NUM_CH-1:0]   req_hi_i,
  input logic [NUM_CH-1:0]   req_lo_n_i,
  input logic                reg_wr_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic [NUM_CH-1:0]   alert_evt_o,
  input logic [NUM_CH-1:0]   sensor_ack_o,
  input logic                lock_en,
  input logic [2*NUM_CH-1:0] mode_bits,
  input logic [NUM_CH-1:0]   state_bits
);
  // R9
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !lock_en |=> !lock_en);

  // R9
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !lock_en |=> $stable(mode_bits));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_c
    // R2
    evt_follows_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (req_hi_i[i] || !req_lo_n_i[i]) |=> alert_evt_o[i]);

    // R5
    ack_has_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      sensor_ack_o[i] |-> $past(req_hi_i[i] || !req_lo_n_i[i] ||
        (reg_wr_i && reg_addr_i == ADDR_W'(OFS_STATE) && reg_wdata_i[i])));

    // R7
    no_ack_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      sensor_ack_o[i] |-> !$past(mode_bits[2*i+1]));

    // R8
    state_holds_evt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      alert_evt_o[i] |-> state_bits[i]);
  end
endmodule

bind sensor_alert_ack_ctrl sac_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .req_hi_i     (req_hi_i),
  .req_lo_n_i   (req_lo_n_i),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .alert_evt_o  (alert_evt_o),
  .sensor_ack_o (sensor_ack_o),
  .lock_en      (lock_en),
  .mode_bits    (mode_bits),
  .state_bits   (state_bits)
);

// File: tb/sensor_alert_ack_ctrl_tb.sv
`timescale 1ns/1ps
module sensor_alert_ack_ctrl_tb;
  localparam int N  = 13;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  req_hi;
  logic [N-1:0]  req_lo_n;
  logic          wr, rd;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [N-1:0]  evt, ack;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sensor_alert_ack_ctrl #(.NUM_CH(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i        (clk),
    .rst_i        (rst),
    .req_hi_i     (req_hi),
    .req_lo_n_i   (req_lo_n),
    .reg_wr_i     (wr),
    .reg_rd_i     (rd),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .alert_evt_o  (evt),
    .sensor_ack_o (ack)
  );

  task automatic check(string rid, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rid, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_write(int a, logic [31:0] d);
    wr = 1'b1; addr = AW'(a); wdata = d;
    tick();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(int a, output logic [31:0] d);
    rd = 1'b1; addr = AW'(a);
    tick();
    d = rdata;
    rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 evt", 32'(evt), 0);
    check("R1 ack", 32'(ack), 0);
    reg_read('h04, d); check("R1 lock", d, 1);
    reg_read('h08, d); check("R1 mode", d, 0);
    reg_read('h0C, d); check("R1 trig", d, 0);
    reg_read('h10, d); check("R1 state", d, 0);
  endtask

  task automatic t_detect();
    // R2 R3 R5: default policy is hardware acknowledge
    req_hi[0] = 1'b1; tick();
    check("R2 high line", 32'(evt), 32'h1);
    check("R5 hw ack", 32'(ack), 32'h1);
    req_hi[0] = 1'b0; tick();
    check("R3 drops", 32'(evt), 0);
    check("R5 ack single", 32'(ack), 0);
    req_lo_n[1] = 1'b0; tick();
    check("R2 low line", 32'(evt), 32'h2);
    req_lo_n[1] = 1'b1;
    req_hi[2] = 1'b1; req_lo_n[2] = 1'b0; tick();
    check("R2 both lines", 32'(evt), 32'h4);
    req_hi[2] = 1'b0; req_lo_n[2] = 1'b1; tick();
    tick();
    check("R2 idle pair", 32'(evt), 0);
  endtask

  task automatic t_mode_rb();
    logic [31:0] d;
    // ch3 code 1, ch4 code 2, ch5 code 3
    reg_write('h08, 32'h0000_0C40 | 32'h0000_0200);
    reg_read('h08, d);
    check("R4 readback", d, 32'h0000_0E40);
  endtask

  task automatic t_sw_ack();
    logic [31:0] d;
    req_hi[3] = 1'b1; tick();
    check("R6 evt", 32'(evt), 32'h8);
    check("R6 no early ack", 32'(ack), 0);
    req_hi[3] = 1'b0; tick();
    check("R6 still no ack", 32'(ack), 0);
    reg_read('h10, d);
    check("R8 sticky", d, 32'hF);
    reg_write('h10, 32'h8);
    check("R6 ack on clear", 32'(ack), 32'h8);
    reg_read('h10, d);
    check("R8 cleared", d, 32'h7);
    reg_write('h10, 32'h1);
    check("R5 clear gives no ack", 32'(ack), 0);
    reg_write('h10, 32'h8);
    check("R6 clear of zero bit", 32'(ack), 0);
    reg_write('h10, 32'h0);
    reg_read('h10, d);
    check("R8 write zero keeps", d, 32'h6);
  endtask

  task automatic t_no_ack();
    req_hi[4] = 1'b1; req_lo_n[5] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R7 repeated evt", 32'(evt), 32'h30);
      check("R7 no ack", 32'(ack), 0);
    end
    req_hi[4] = 1'b0; req_lo_n[5] = 1'b1; tick();
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    req_hi[9] = 1'b1;
    reg_write('h10, 32'h200);
    req_hi[9] = 1'b0;
    reg_read('h10, d);
    check("R8 set wins", d & 32'h200, 32'h200);
  endtask

  task automatic t_pulse();
    logic [31:0] d;
    reg_write('h00, 32'h40);
    check("R10 one evt", 32'(evt), 32'h40);
    check("R10 no ack", 32'(ack), 0);
    tick();
    check("R10 single", 32'(evt), 0);
    reg_read('h00, d);
    check("R10 reads zero", d, 0);
    reg_read('h10, d);
    check("R10 state", d & 32'h40, 32'h40);
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    reg_write('h0C, 32'h80);
    check("R11 not yet", 32'(evt), 0);
    tick();
    check("R11 forced", 32'(evt), 32'h80);
    tick();
    check("R11 continuous", 32'(evt), 32'h80);
    check("R11 no ack", 32'(ack), 0);
    reg_read('h0C, d);
    check("R11 readback", d, 32'h80);
    reg_write('h0C, 32'h0);
    tick();
    check("R11 stopped", 32'(evt), 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    reg_write('h04, 32'h1);
    reg_read('h04, d); check("R9 write one no effect", d, 1);
    reg_write('h04, 32'h0);
    reg_read('h04, d); check("R9 cleared", d, 0);
    reg_write('h04, 32'h1);
    reg_read('h04, d); check("R9 stays clear", d, 0);
    reg_write('h08, 32'h0);
    reg_read('h08, d); check("R9 mode locked", d, 32'h0E40);
    req_hi[3] = 1'b1; tick();
    check("R9 sw policy kept", 32'(ack), 0);
    req_hi[3] = 1'b0; tick();
  endtask

  task automatic t_undef();
    logic [31:0] d;
    wr = 1'b0; rd = 1'b1; addr = AW'('h14);
    tick();
    check("R12 one cycle latency", rdata, 0);
    rd = 1'b0;
    reg_read('h1C, d); check("R12 undefined", d, 0);
    reg_read('h0C, d); check("R12 defined", d, 0);
  endtask

  initial begin
    rst = 1'b1; req_hi = '0; req_lo_n = '1;
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_detect();
    t_mode_rb();
    t_sw_ack();
    t_no_ack();
    t_set_wins();
    t_pulse();
    t_trigger();
    t_lock();
    t_undef();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule